// File: doc/BRIEF.md
# Collective Write Data Striper

This block sits between a memory response port and a group of local SRAM banks that together form one logical buffer. A command gives a starting offset, a length in bytes and a placement mode. The block then takes the sequential response words one at a time under a valid/ready handshake and steers each word to one bank, at the local address that the mode dictates.

In concatenated placement the banks act as one long array. The first bank's address range fills before the next bank takes over. In interleaved placement consecutive words rotate across the banks, so a row-major stream lands column-major without any extra pass. A single-cycle completion pulse reports that the last word has been presented to its bank. Only then is a new command taken.

Top module: `bank_stripe_writer`

## Requirements
- R1: After reset `cmd_ready` is 1, and `in_ready`, `done` and every bit of `bank_we` are 0.
- R2: A command of B bytes writes exactly ceil(B / (DATA_W/8)) words, so a partial last word counts as a whole word.
- R3: With `cmd_interleave` = 0 (concatenated), word i goes to global index g = (offset + i) mod (NUM_BANKS*BANK_DEPTH). The bank is g div BANK_DEPTH and the local address is g mod BANK_DEPTH.
- R4: With `cmd_interleave` = 1 (interleaved), word i goes to bank i mod NUM_BANKS at local address ((offset mod BANK_DEPTH) + i div NUM_BANKS) mod BANK_DEPTH.
- R5: Words are written in arrival order with their data unchanged. At most one bank strobe is high in a cycle. The strobe for a word appears in the cycle after the edge that accepted it.
- R6: `in_ready` is high only while the current command still has words to take. Data offered while no transfer is active produces no write.
- R7: `done` is high for exactly one cycle, two cycles after the edge that accepts the final word. `cmd_ready` is high in that same cycle.
- R8: A command is taken only while `cmd_ready` is high. A command offered during a transfer has no effect on the transfer in progress.
- R9: A zero-byte command produces no write. Its `done` pulse follows two cycles after the command is accepted.
- R10: Gaps in `in_valid` stall the transfer without changing the placement of any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_interleave | input | 1 | 0 = concatenated, 1 = interleaved placement |
| cmd_offset | input | $clog2(NUM_BANKS*BANK_DEPTH) | Starting offset (global index or local address) |
| cmd_bytes | input | LEN_W | Transfer length in bytes |
| in_valid | input | 1 | Response word offered |
| in_ready | output | 1 | Response word can be taken |
| in_data | input | DATA_W | Response word |
| bank_we | output | NUM_BANKS | Per-bank write strobe |
| bank_addr | output | NUM_BANKS*$clog2(BANK_DEPTH) | Per-bank local address, bank b at slice b |
| bank_wdata | output | NUM_BANKS*DATA_W | Per-bank write data, bank b at slice b |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong word counter or a bad placement term shows up at the per-bank write ports. The affected strobe lands on the wrong bank or the wrong address in the same cycle the word is presented, one cycle after the word was accepted. Each strobe is decoded from its data tag back to its word index, so an out-of-order write or a dropped write is seen at the first word it affects. A counter that stops one word early or one word late changes the number of strobes and shifts the `done` pulse by a cycle. Checks on the exact cycle of `done` and on the strobe count catch both cases at the end of that transfer.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } stripe_state_e;

   typedef enum logic {
      LAY_CONCAT = 1'b0,
      LAY_ROTATE = 1'b1
   } stripe_layout_e;

endpackage

// File: rtl/stripe_ctrl.sv
module stripe_ctrl
   import stripe_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 12,
   parameter int GW     = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic                 cmd_interleave,
   input  logic [GW-1:0]        cmd_offset,
   input  logic [LEN_W-1:0]     cmd_bytes,
   input  logic                 in_valid,
   output logic                 cmd_ready,
   output logic                 in_ready,
   output logic                 beat,
   output logic [GW-1:0]        word_idx,
   output stripe_layout_e       layout,
   output logic [GW-1:0]        base_off,
   output logic                 done
);

   localparam int BPW = DATA_W / 8;
   localparam int BSH = $clog2(BPW);

   stripe_state_e      state_q;
   logic [LEN_W-1:0]   idx_q;
   logic [LEN_W-1:0]   total_q;
   logic [LEN_W:0]     byte_sum;
   logic [LEN_W-1:0]   words_req;
   logic               last_beat;
   logic               done_q;

   // round the byte count up to whole words
   always_comb begin
      byte_sum  = {1'b0, cmd_bytes} + (LEN_W+1)'(BPW - 1);
      words_req = LEN_W'(byte_sum >> BSH);
   end

   assign cmd_ready = (state_q == ST_IDLE);
   assign in_ready  = (state_q == ST_RUN);
   assign beat      = in_ready && in_valid;
   assign last_beat = (idx_q == total_q - 1'b1);
   assign word_idx  = idx_q[GW-1:0];
   assign done      = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         total_q  <= '0;
         layout   <= LAY_CONCAT;
         base_off <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= (state_q == ST_FIN);
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  layout   <= cmd_interleave ? LAY_ROTATE : LAY_CONCAT;
                  base_off <= cmd_offset;
                  total_q  <= words_req;
                  idx_q    <= '0;
                  state_q  <= (words_req == '0) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               if (in_valid) begin
                  idx_q <= idx_q + 1'b1;
                  if (last_beat) state_q <= ST_FIN;
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (idx_q < total_q)); // R2

   AST_NO_CMD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !cmd_ready); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

endmodule

// File: rtl/stripe_addr_gen.sv
module stripe_addr_gen
   import stripe_pkg::*;
#(
   parameter int NUM_BANKS  = 4,
   parameter int BANK_DEPTH = 16
) (
   input  stripe_layout_e                                   layout,
   input  logic [$clog2(NUM_BANKS*BANK_DEPTH)-1:0]          base_off,
   input  logic [$clog2(NUM_BANKS*BANK_DEPTH)-1:0]          word_idx,
   output logic [$clog2(NUM_BANKS)-1:0]                     bank_sel,
   output logic [$clog2(BANK_DEPTH)-1:0]                    local_addr
);

   localparam int BW = $clog2(NUM_BANKS);
   localparam int AW = $clog2(BANK_DEPTH);
   localparam int GW = BW + AW;

   logic [GW-1:0] flat_idx;
   logic [AW-1:0] rot_addr;

   // both bank count and depth are powers of two: div and mod are slices
   always_comb begin
      flat_idx = base_off + word_idx;
      rot_addr = base_off[AW-1:0] + word_idx[GW-1:BW];
      if (layout == LAY_ROTATE) begin
         bank_sel   = word_idx[BW-1:0];
         local_addr = rot_addr;
      end else begin
         bank_sel   = flat_idx[GW-1:AW];
         local_addr = flat_idx[AW-1:0];
      end
   end

endmodule

// File: rtl/stripe_bank_ports.sv
module stripe_bank_ports #(
   parameter int NUM_BANKS = 4,
   parameter int AW        = 4,
   parameter int DATA_W    = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fire,
   input  logic [$clog2(NUM_BANKS)-1:0]  bank_sel,
   input  logic [AW-1:0]                 local_addr,
   input  logic [DATA_W-1:0]             wdata,
   output logic [NUM_BANKS-1:0]          bank_we,
   output logic [NUM_BANKS*AW-1:0]       bank_addr,
   output logic [NUM_BANKS*DATA_W-1:0]   bank_wdata
);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = fire && (bank_sel == b[$clog2(NUM_BANKS)-1:0]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bank_we[b]                    <= 1'b0;
            bank_addr[b*AW +: AW]         <= '0;
            bank_wdata[b*DATA_W +: DATA_W] <= '0;
         end else begin
            bank_we[b] <= hit;
            if (hit) begin
               bank_addr[b*AW +: AW]          <= local_addr;
               bank_wdata[b*DATA_W +: DATA_W] <= wdata;
            end
         end
      end
   end

endmodule

// File: rtl/bank_stripe_writer.sv
module bank_stripe_writer
   import stripe_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_BANKS  = 4,
   parameter int BANK_DEPTH = 16,
   parameter int LEN_W      = 12
) (
   input  logic                                            clk,
   input  logic                                            rst_n,
   input  logic                                            cmd_valid,
   output logic                                            cmd_ready,
   input  logic                                            cmd_interleave,
   input  logic [$clog2(NUM_BANKS*BANK_DEPTH)-1:0]         cmd_offset,
   input  logic [LEN_W-1:0]                                cmd_bytes,
   input  logic                                            in_valid,
   output logic                                            in_ready,
   input  logic [DATA_W-1:0]                               in_data,
   output logic [NUM_BANKS-1:0]                            bank_we,
   output logic [NUM_BANKS*$clog2(BANK_DEPTH)-1:0]         bank_addr,
   output logic [NUM_BANKS*DATA_W-1:0]                     bank_wdata,
   output logic                                            done
);

   localparam int BW = $clog2(NUM_BANKS);
   localparam int AW = $clog2(BANK_DEPTH);
   localparam int GW = BW + AW;

   if (NUM_BANKS < 2 || (1 << BW) != NUM_BANKS) begin : g_chk_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (BANK_DEPTH < 2 || (1 << AW) != BANK_DEPTH) begin : g_chk_depth
      $error("BANK_DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 16 || (DATA_W % 8) != 0 || (1 << $clog2(DATA_W/8)) != DATA_W/8) begin : g_chk_width
      $error("DATA_W must be a power-of-two byte count of at least two bytes");
   end
   if (LEN_W < GW) begin : g_chk_len
      $error("LEN_W must cover the global index width");
   end

   logic              beat;
   logic [GW-1:0]     word_idx;
   logic [GW-1:0]     base_off;
   stripe_layout_e    layout;
   logic [BW-1:0]     bank_sel;
   logic [AW-1:0]     local_addr;

   stripe_ctrl #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W),
      .GW     (GW)
   ) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_valid      (cmd_valid),
      .cmd_interleave (cmd_interleave),
      .cmd_offset     (cmd_offset),
      .cmd_bytes      (cmd_bytes),
      .in_valid       (in_valid),
      .cmd_ready      (cmd_ready),
      .in_ready       (in_ready),
      .beat           (beat),
      .word_idx       (word_idx),
      .layout         (layout),
      .base_off       (base_off),
      .done           (done)
   );

   stripe_addr_gen #(
      .NUM_BANKS  (NUM_BANKS),
      .BANK_DEPTH (BANK_DEPTH)
   ) u_addr (
      .layout     (layout),
      .base_off   (base_off),
      .word_idx   (word_idx),
      .bank_sel   (bank_sel),
      .local_addr (local_addr)
   );

   stripe_bank_ports #(
      .NUM_BANKS (NUM_BANKS),
      .AW        (AW),
      .DATA_W    (DATA_W)
   ) u_ports (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (beat),
      .bank_sel   (bank_sel),
      .local_addr (local_addr),
      .wdata      (in_data),
      .bank_we    (bank_we),
      .bank_addr  (bank_addr),
      .bank_wdata (bank_wdata)
   );

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we)); // R5

   AST_STROBE_FROM_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (|bank_we) |-> $past(beat)); // R5

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cmd_ready); // R7

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !done) |=> !(|bank_we)); // R6

endmodule

// File: tb/bank_stripe_writer_tb_top.sv
module bank_stripe_writer_tb_top;

   localparam int DW = 32;
   localparam int NB = 4;
   localparam int DP = 16;
   localparam int LW = 12;
   localparam int AW = $clog2(DP);
   localparam int GW = $clog2(NB*DP);

   typedef struct packed {
      logic          rot;
      logic [GW-1:0] off;
      logic [LW-1:0] bytes;
      logic          stall;
      logic [LW-1:0] words;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 6'd0,  12'd16, 1'b0, 12'd4},   // concat aligned
      '{1'b0, 6'd14, 12'd20, 1'b0, 12'd5},   // concat crosses bank edge
      '{1'b1, 6'd3,  12'd32, 1'b0, 12'd8},   // rotate two passes
      '{1'b1, 6'd15, 12'd30, 1'b0, 12'd8},   // rotate local wrap, rounding
      '{1'b0, 6'd62, 12'd9,  1'b0, 12'd3},   // concat global wrap, rounding
      '{1'b1, 6'd0,  12'd1,  1'b1, 12'd1},   // single byte
      '{1'b0, 6'd30, 12'd24, 1'b1, 12'd6}    // stalled concat
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_ready;
   logic              cmd_interleave = 1'b0;
   logic [GW-1:0]     cmd_offset = '0;
   logic [LW-1:0]     cmd_bytes = '0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [DW-1:0]     in_data = '0;
   logic [NB-1:0]     bank_we;
   logic [NB*AW-1:0]  bank_addr;
   logic [NB*DW-1:0]  bank_wdata;
   logic              done;

   int checks = 0;
   int failures = 0;
   int seen = 0;
   int cycles = 0;
   logic cur_rot = 1'b0;
   int   cur_off = 0;
   int   cur_base = 0;

   always #2 clk = ~clk;

   bank_stripe_writer #(
      .DATA_W(DW), .NUM_BANKS(NB), .BANK_DEPTH(DP), .LEN_W(LW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_interleave(cmd_interleave), .cmd_offset(cmd_offset), .cmd_bytes(cmd_bytes),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
      .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void place(input logic rot, input int off, input int i,
                                 output int b, output int a);
      int g;
      if (rot) begin
         b = i % NB;
         a = ((off % DP) + i / NB) % DP;
      end else begin
         g = (off + i) % (NB*DP);
         b = g / DP;
         a = g % DP;
      end
   endfunction

   // strobe monitor: decodes each write back to its word index
   always @(negedge clk) begin
      if (rst_n && (|bank_we)) begin
         chk($countones(bank_we) == 1, "R5 one strobe", $countones(bank_we), 1);
         for (int b = 0; b < NB; b++) begin
            if (bank_we[b]) begin
               int idx, eb, ea;
               idx = int'(bank_wdata[b*DW +: DW]) - cur_base;
               place(cur_rot, cur_off, idx, eb, ea);
               chk(idx == seen, "R5 order", idx, seen);
               if (cur_rot) begin
                  chk(b == eb, "R4 bank", b, eb);
                  chk(int'(bank_addr[b*AW +: AW]) == ea, "R4 addr", int'(bank_addr[b*AW +: AW]), ea);
               end else begin
                  chk(b == eb, "R3 bank", b, eb);
                  chk(int'(bank_addr[b*AW +: AW]) == ea, "R3 addr", int'(bank_addr[b*AW +: AW]), ea);
               end
            end
         end
         seen++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic issue(input logic rot, input int off, input int bytes, input int base);
      cur_rot  = rot;
      cur_off  = off;
      cur_base = base;
      seen     = 0;
      cmd_valid      = 1'b1;
      cmd_interleave = rot;
      cmd_offset     = GW'(off);
      cmd_bytes      = LW'(bytes);
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic push(input int d);
      in_valid = 1'b1;
      in_data  = DW'(d);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // called at the negedge just after the last accepting edge
   task automatic expect_done(input string req, input int words);
      chk(done == 1'b0, req, int'(done), 0);
      @(negedge clk);
      chk(done == 1'b1, req, int'(done), 1);
      chk(cmd_ready == 1'b1, "R7 ready with done", int'(cmd_ready), 1);
      chk(seen == words, "R2 word count", seen, words);
      @(negedge clk);
      chk(done == 1'b0, "R7 single pulse", int'(done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
      chk(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
      chk(done == 1'b0, "R1 done", int'(done), 0);
      chk(bank_we == '0, "R1 strobes", int'(bank_we), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: data offered while idle is dropped
      seen = 0;
      in_valid = 1'b1;
      in_data  = 32'hDEAD;
      repeat (5) begin
         @(negedge clk);
         chk(in_ready == 1'b0, "R6 idle ready", int'(in_ready), 0);
      end
      in_valid = 1'b0;
      @(negedge clk);
      chk(seen == 0, "R6 idle writes", seen, 0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         int base;
         base = (v + 1) << 16;
         issue(VECS[v].rot, int'(VECS[v].off), int'(VECS[v].bytes), base);
         for (int i = 0; i < int'(VECS[v].words); i++) begin
            if (VECS[v].stall) begin
               @(negedge clk);
               chk(seen == i, "R10 stall holds", seen, i);
            end
            push(base + i);
         end
         expect_done("R7 done timing", int'(VECS[v].words));
      end

      // R8: command offered mid-transfer is ignored
      issue(1'b1, 5, 24, 32'h0009_0000);
      push(32'h0009_0000);
      push(32'h0009_0001);
      cmd_valid = 1'b1;
      cmd_interleave = 1'b0;
      cmd_offset = GW'(40);
      cmd_bytes  = LW'(4);
      chk(cmd_ready == 1'b0, "R8 busy", int'(cmd_ready), 1'b0);
      for (int i = 2; i < 6; i++) push(32'h0009_0000 + i);
      cmd_valid = 1'b0;
      expect_done("R8 done timing", 6);

      // R9: zero-byte command
      issue(1'b0, 7, 0, 32'h000A_0000);
      chk(in_ready == 1'b0, "R9 no data phase", int'(in_ready), 0);
      expect_done("R9 done timing", 0);

      // R2: rounding boundary just above a whole word
      issue(1'b0, 0, 5, 32'h000B_0000);
      push(32'h000B_0000);
      chk(in_ready == 1'b1, "R2 second word", int'(in_ready), 1);
      push(32'h000B_0001);
      expect_done("R2 done timing", 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule